// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 512K locations by 8 bits. The host issues one transfer at a time with a single-cycle request strobe, a write/read select, an address and write data. The controller then produces the memory's active-low select, output-enable and write-enable strobes. It presents the address and drives or samples the bidirectional data bus through separate output, drive-enable and input signals. The host sees `busy` while a transfer is in progress and a one-cycle `done` when it finishes. Read data is returned on `rsp_rdata`.

Every phase of a memory cycle is stretched to a whole number of clock cycles. Each count is computed at elaboration by rounding up a nanosecond limit divided by the clock period, for example write pulse width, data setup or read access time. Writes are controlled by write enable, with output enable kept high, so the memory never drives the bus while the controller does. After each read the controller waits out the memory's output turn-off time before any new transfer can begin. Between transfers the memory is deselected so that it falls into its automatic power-down state.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low, and `busy` and `done` are low.
- R2: A write request stores `req_wdata` at `req_addr`. The write takes place while `mem_ce_n` and `mem_we_n` are both low, and it completes with `done`.
- R3: A read request holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for RD_CYC cycles. RD_CYC is the largest of the rounded-up read-cycle, address-access and output-enable-access times. The data bus is sampled on the last of these cycles and appears on `rsp_rdata` together with `done`.
- R4: Each write-enable low pulse lasts at least WR_CYC cycles. WR_CYC is the largest of the rounded-up write-cycle, pulse-width, address-setup and data-setup times, which is 3 cycles at the default 20 ns period.
- R5: `mem_dq_oe` is high only in cycles where `mem_we_n` is low.
- R6: `mem_oe_n` is high in every cycle where `mem_we_n` is low.
- R7: Every accepted request produces exactly one `done` pulse, and that pulse lasts one cycle.
- R8: A request presented while `busy` is high is ignored. It causes no memory access and no `done`.
- R9: After `mem_oe_n` rises at the end of a read, `mem_dq_oe` stays low for at least TURN_CYC+1 cycles. TURN_CYC is the rounded-up output-disable time, and the extra cycle separates a read from a following write.
- R10: While `busy` is low, `mem_ce_n` is high, so the idle memory is deselected.
- R11: `mem_addr` does not change while `mem_ce_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Transfer address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Data returned by the last read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address lines |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers |
| mem_dq_in | input | 8 | Data received from the memory |

## Verification
The bound checker watches the strobe relationships on every cycle: drivers only under write enable, output enable high during writes, write enable high during reads, a minimum write pulse, address stability under select, idle deselect and single-cycle `done`. The bench's memory model can only show by scenario that stored data really comes back. It returns inverted data to any read sampled before RD_CYC cycles have elapsed, so early sampling shows up as wrong data. Scenarios also show that requests made while busy leave memory untouched, and that a write following a read waits out the turnaround gap.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WPULSE = 2'd1,
    ST_RACC   = 2'd2,
    ST_RTURN  = 2'd3
  } seq_state_e;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned WR_CYC   = 3,
  parameter int unsigned RD_CYC   = 3,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_zero,
  output logic             accept,
  output logic             cap_rd,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_oe,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  seq_state_e state_q;

  always_comb begin
    accept   = (state_q == ST_IDLE) && req_valid;
    cap_rd   = (state_q == ST_RACC) && tmr_zero;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = req_write ? WR_LAST : RD_LAST;
    end else if (cap_rd) begin
      tmr_load = 1'b1;
      tmr_val  = TURN_LAST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            busy <= 1'b1;
            ce_n <= 1'b0;
            if (req_write) begin
              we_n    <= 1'b0;
              dq_oe   <= 1'b1;
              state_q <= ST_WPULSE;
            end else begin
              oe_n    <= 1'b0;
              state_q <= ST_RACC;
            end
          end
        end
        ST_WPULSE: begin
          if (tmr_zero) begin
            we_n    <= 1'b1;
            ce_n    <= 1'b1;
            dq_oe   <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RACC: begin
          if (tmr_zero) begin
            ce_n    <= 1'b1;
            oe_n    <= 1'b1;
            state_q <= ST_RTURN;
          end
        end
        ST_RTURN: begin
          if (tmr_zero) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              cap_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
    end else if (cap_rd) begin
      rsp_rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_PWE_NS  = 45,
  parameter int unsigned T_AW_NS   = 45,
  parameter int unsigned T_SD_NS   = 30,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_DOE_NS  = 25,
  parameter int unsigned T_HZOE_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned WR_CYC = max2(max2(ns_to_cyc(T_WC_NS, CLK_NS), ns_to_cyc(T_PWE_NS, CLK_NS)),
                                        max2(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)));
  localparam int unsigned RD_CYC = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                        ns_to_cyc(T_DOE_NS, CLK_NS));
  localparam int unsigned TURN_CYC = ns_to_cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned CNT_W    = $clog2(max2(WR_CYC, max2(RD_CYC, TURN_CYC)) + 1);

  logic             accept;
  logic             cap_rd;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  sram_phase_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram_seq_ctrl #(
    .CNT_W    (CNT_W),
    .WR_CYC   (WR_CYC),
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_zero  (tmr_zero),
    .accept    (accept),
    .cap_rd    (cap_rd),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .dq_oe     (mem_dq_oe),
    .busy      (busy),
    .done      (done)
  );

  sram_dq_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .cap_rd     (cap_rd),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned WR_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  logic [15:0] we_lo_cnt;

  always_ff @(posedge clk) begin
    if (rst || mem_we_n) we_lo_cnt <= '0;
    else                 we_lo_cnt <= we_lo_cnt + 1'b1;
  end

  // R3
  read_we_high_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n);

  // R4
  we_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_lo_cnt >= 16'(WR_CYC)));

  // R5
  bus_drive_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n);

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> mem_ce_n);

  // R11
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .WR_CYC (WR_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_oe (mem_dq_oe),
  .mem_addr  (mem_addr)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int CLK_NS   = 20;
  localparam int WR_EXP   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int RD_EXP   = (55 + CLK_NS - 1) / CLK_NS;
  localparam int TURN_EXP = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr  = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        busy, done;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl u_sram_async_ctrl (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata), .busy (busy), .done (done),
    .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
    .mem_addr (mem_addr), .mem_dq_out (mem_dq_out),
    .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { bit w; logic [18:0] a; logic [7:0] d; } item_t;
  item_t exp_q[$];
  logic [7:0] ref_mem [int];
  logic [7:0] model  [int];

  function automatic logic [7:0] model_get(input logic [18:0] a);
    if (model.exists(int'(a))) return model[int'(a)];
    return 8'h00;
  endfunction

  task automatic fail(input string req, input logic [31:0] act, input logic [31:0] expv);
    errors++;
    $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural memory: read data is inverted until the access count has elapsed.
  int acc_cnt = 0;
  int wlow = 0;
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_oe_n) acc_cnt <= acc_cnt + 1;
    else                        acc_cnt <= 0;
  end

  always @(*) begin
    if (!mem_ce_n && !mem_oe_n && acc_cnt >= RD_EXP - 1) mem_dq_in = model_get(mem_addr);
    else                                                 mem_dq_in = ~model_get(mem_addr);
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_dq_oe && mem_we_n) fail("R5 drive without we", 1, 0);
      if (!mem_ce_n && !mem_we_n) begin
        wlow++;
        model[int'(mem_addr)] = mem_dq_out;
        if (!mem_dq_oe) fail("R5 write without drive", 0, 1);
        if (!mem_oe_n)  fail("R6 oe low during write", 0, 1);
      end else if (wlow != 0) begin
        checks++;
        if (wlow < WR_EXP) fail("R4 write pulse", wlow, WR_EXP);
        wlow = 0;
      end
    end
  end

  // Scoreboard monitor and turnaround gap.
  bit prev_done = 0;
  int gap = 0;
  bit after_read = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        checks++;
        if (prev_done) fail("R7 done longer than one cycle", 2, 1);
        if (exp_q.size() == 0) begin
          fail("R8 unexpected done", 1, 0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          if (it.w) begin
            if (model_get(it.a) !== it.d) fail("R2 stored data", model_get(it.a), it.d);
          end else begin
            if (rsp_rdata !== it.d) fail("R3 read data", rsp_rdata, it.d);
          end
        end
      end
      prev_done = done;
      if (!busy && !mem_ce_n) fail("R10 idle not deselected", 0, 1);
      if (!mem_oe_n) begin
        gap = 0; after_read = 1;
      end else if (mem_dq_oe) begin
        if (after_read) begin
          checks++;
          if (gap < TURN_EXP + 1) fail("R9 turnaround", gap, TURN_EXP + 1);
        end
        after_read = 0;
      end else begin
        gap++;
      end
    end
  end

  task automatic issue(input bit w, input logic [18:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    if (w) ref_mem[int'(a)] = d;
    it.w = w; it.a = a;
    it.d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  // Drive a request for one cycle while the controller is busy.
  task automatic poke_busy(input bit w, input logic [18:0] a, input logic [7:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail("watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    checks++; if (mem_ce_n !== 1'b1)  fail("R1 ce_n", mem_ce_n, 1);
    checks++; if (mem_oe_n !== 1'b1)  fail("R1 oe_n", mem_oe_n, 1);
    checks++; if (mem_we_n !== 1'b1)  fail("R1 we_n", mem_we_n, 1);
    checks++; if (mem_dq_oe !== 1'b0) fail("R1 dq_oe", mem_dq_oe, 0);
    checks++; if (busy !== 1'b0)      fail("R1 busy", busy, 0);
    checks++; if (done !== 1'b0)      fail("R1 done", done, 0);

    // R2 R3 boundary addresses
    issue(1, 19'h00000, 8'h3C);
    issue(1, 19'h7FFFF, 8'hFF);
    issue(1, 19'h00001, 8'h00);
    issue(0, 19'h00000, 8'h00);
    issue(0, 19'h7FFFF, 8'h00);
    issue(0, 19'h00001, 8'h00);

    // Spread of patterns
    for (int i = 0; i < 16; i++) issue(1, 19'((i * 32'h8001) ^ 32'h2A5A5), 8'((i * 37) + 5));
    for (int i = 15; i >= 0; i--) issue(0, 19'((i * 32'h8001) ^ 32'h2A5A5), 8'h00);

    // R9 read immediately followed by write, then overwrite
    issue(0, 19'h00000, 8'h00);
    issue(1, 19'h00000, 8'hC3);
    issue(0, 19'h00000, 8'h00);

    // R8 requests while busy are ignored
    issue(1, 19'h00100, 8'h11);
    poke_busy(1, 19'h00100, 8'hEE);
    issue(0, 19'h00100, 8'h00);
    poke_busy(1, 19'h00100, 8'h77);
    issue(0, 19'h00100, 8'h00);

    repeat (12) @(negedge clk);
    // R7 every accepted transfer completed, none extra
    checks++;
    if (exp_q.size() != 0) fail("R7 missing done", exp_q.size(), 0);
    checks++;
    if (busy !== 1'b0 || mem_ce_n !== 1'b1) fail("R10 final idle", {busy, mem_ce_n}, 2'b01);
    finish_sim();
  end

endmodule